// File: doc/BRIEF.md
# Address Translation Unit with Page Permission Checking

This block turns a processor virtual address into a physical address, one request at a time. A small fully associative cache of recent translations answers most requests on its own and touches no memory. When a page is not held there, the block reads that page's entry from a single-level page table in memory over a plain request/response port. If the entry is valid it stores the entry in the cache, then finishes the translation.

Each access is checked against the access type and privilege mode of the request. The check covers hits as well as freshly fetched entries. A page whose entry is not valid produces a page-fault response. A valid page that forbids the access produces a protection-fault response. In both cases no address is returned. Software sets the table base through a configuration strobe and can empty the translation cache with a one-cycle flush pulse.

Top module: `xlat_mmu`

## Requirements
- R1: A request whose page is cached gives `rsp_valid` in the cycle after it is accepted, with no memory read. `rsp_paddr` is the cached frame number above the unchanged low 12 offset bits of `req_vaddr`.
- R2: A request whose page is not cached makes exactly one memory read at table base + page number × 4. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. The response comes two cycles after `mem_rsp_valid`.
- R3: A page-table word has bit 0 = valid, bit 1 = write allowed, bit 2 = execute allowed, bit 3 = supervisor only, and the frame number in bits 31:12. Bits 11:4 are ignored.
- R4: A fetched entry with bit 0 clear gives `rsp_page_fault`=1, `rsp_prot_fault`=0 and `rsp_paddr`=0. Such an entry is not cached, so the next access to that page reads the table again.
- R5: `req_kind` 2'b01 (write) needs the write bit and 2'b10 (instruction fetch) needs the execute bit. 2'b00 and 2'b11 are reads and need neither. A supervisor-only page needs `req_super`=1. Any breach gives `rsp_prot_fault`=1 and `rsp_paddr`=0, on cache hits as well as after a walk.
- R6: The cache holds 8 entries and refills them in round-robin order. After 8 cached pages, a ninth walked page replaces the oldest fill, and the other pages stay cached.
- R7: A `tlb_flush` pulse empties the cache, so every later access walks the table.
- R8: Only one request is in flight. `req_ready` is low from acceptance until the response, and exactly one response is given per request.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, the cache is empty and the table base is 0.
- R10: The table base is loaded from `cfg_base` when `cfg_base_we` is 1, and later walks use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Load strobe for the table base |
| cfg_base | input | 32 | New page-table base byte address |
| tlb_flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_super | input | 1 | Requester runs in supervisor mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_page_fault | output | 1 | Entry not valid |
| rsp_prot_fault | output | 1 | Access not permitted |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Page-table entry byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry word |

## Verification
The bench checks that a page whose entry is invalid is walked again on every access. A design that cached faulting entries would answer the second attempt from the cache without a memory read. Protection is tested on cache hits as well as on walks, so a checker wired only to the walk path would return an address for a forbidden fetch or a user access to a supervisor page. Nine distinct pages are filled to force an eviction, and the bench checks that the oldest page walks again while a newer one still hits, which exposes a wrong replacement pointer. Flush and a base change are each followed by a walk whose read address is compared, which catches a stale cache or a base register that never loads.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  typedef struct packed {
    logic sup;
    logic exe;
    logic wr;
  } perm_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FETCH,
    ST_REFILL,
    ST_RESPOND
  } walk_st_e;

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output perm_t            lk_perm,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  perm_t            wr_perm
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] tag_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  perm_t            perm_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr_q, rr_d;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_ppn  = ppn_q[i];
        lk_perm = perm_q[i];
      end
    end
  end

  // next-state: flush wins over a refill in the same cycle
  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (wr_en) begin
      vld_d[rr_q] = 1'b1;
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
    if (flush) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[rr_q]  <= wr_vpn;
      ppn_q[rr_q]  <= wr_ppn;
      perm_q[rr_q] <= wr_perm;
    end
  end

  assert_unique_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
#(
  parameter int PPN_W     = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic                   ent_valid,
  input  perm_t                  ent_perm,
  input  logic [PPN_W-1:0]       ent_ppn,
  input  logic [1:0]             acc_kind,
  input  logic                   acc_super,
  input  logic [PAGE_BITS-1:0]   acc_offset,
  output logic                   page_fault,
  output logic                   prot_fault,
  output logic [PPN_W+PAGE_BITS-1:0] paddr
);

  logic denied;

  always_comb begin
    denied = 1'b0;
    if (acc_kind == ACC_WRITE && !ent_perm.wr)  denied = 1'b1;
    if (acc_kind == ACC_FETCH && !ent_perm.exe) denied = 1'b1;
    if (ent_perm.sup && !acc_super)             denied = 1'b1;
  end

  assign page_fault = !ent_valid;
  assign prot_fault = ent_valid && denied;
  assign paddr      = (ent_valid && !denied) ? {ent_ppn, acc_offset} : '0;

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int MEM_DW    = 32,
  parameter int PTE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      req_super,
  input  logic [PA_W-1:0]           ptbase,
  input  logic                      tlb_hit,
  output logic [VA_W-PAGE_BITS-1:0] cur_vpn,
  output logic [PAGE_BITS-1:0]      cur_offset,
  output logic [1:0]                cur_kind,
  output logic                      cur_super,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [PA_W-1:0]           mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [MEM_DW-1:0]         mem_rsp_data,
  output logic                      tlb_we,
  output logic                      use_walk,
  output logic                      pte_valid,
  output logic [PA_W-PAGE_BITS-1:0] pte_ppn,
  output perm_t                     pte_perm,
  output logic                      rsp_valid
);

  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PPN_W     = PA_W - PAGE_BITS;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  walk_st_e          state_q, state_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [1:0]        kind_q;
  logic              sup_q;
  logic              issued_q, issued_d;
  logic [MEM_DW-1:0] pte_q;
  logic              cap_req, cap_pte;
  logic [PA_W-1:0]   vpn_ext;
  logic              pte_unused;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP:  state_d = tlb_hit ? ST_IDLE : ST_FETCH;
      ST_FETCH:   if (issued_q && mem_rsp_valid) state_d = ST_REFILL;
      ST_REFILL:  state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign cap_req = (state_q == ST_IDLE) && req_valid;
  assign cap_pte = (state_q == ST_FETCH) && issued_q && mem_rsp_valid;

  always_comb begin
    issued_d = issued_q;
    if (state_q == ST_LOOKUP) issued_d = 1'b0;
    else if (mem_req_valid && mem_req_ready) issued_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_req) begin
      vpn_q  <= req_vaddr[VA_W-1:PAGE_BITS];
      off_q  <= req_vaddr[PAGE_BITS-1:0];
      kind_q <= req_kind;
      sup_q  <= req_super;
    end
    if (cap_pte) pte_q <= mem_rsp_data;
  end

  assign vpn_ext       = PA_W'(vpn_q);
  assign mem_req_addr  = ptbase + (vpn_ext << PTE_SHIFT);
  assign mem_req_valid = (state_q == ST_FETCH) && !issued_q;
  assign req_ready     = (state_q == ST_IDLE);

  assign pte_valid     = pte_q[0];
  assign pte_perm.wr   = pte_q[1];
  assign pte_perm.exe  = pte_q[2];
  assign pte_perm.sup  = pte_q[3];
  assign pte_ppn       = pte_q[MEM_DW-1 -: PPN_W];
  assign pte_unused    = ^pte_q[MEM_DW-PPN_W-1:4];

  assign tlb_we    = (state_q == ST_REFILL) && pte_valid;
  assign use_walk  = (state_q == ST_RESPOND);
  assign rsp_valid = ((state_q == ST_LOOKUP) && tlb_hit) || (state_q == ST_RESPOND);

  assign cur_vpn    = vpn_q;
  assign cur_offset = off_q;
  assign cur_kind   = kind_q;
  assign cur_super  = sup_q;

  assert_hit_no_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && tlb_hit) |=> (req_ready && !mem_req_valid));

  assert_hold_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_free_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu
  import xlat_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int MEM_DW      = 32,
  parameter int TLB_ENTRIES = 8,
  parameter int PTE_BYTES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_base_we,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic              tlb_flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_super,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_page_fault,
  output logic              rsp_prot_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [MEM_DW-1:0] mem_rsp_data
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  logic [PA_W-1:0]      base_q;
  logic                 tlb_hit, tlb_we, use_walk, pte_valid, walk_rsp;
  logic [PPN_W-1:0]     tlb_ppn, pte_ppn, chk_ppn;
  perm_t                tlb_perm, pte_perm, chk_perm;
  logic [VPN_W-1:0]     cur_vpn;
  logic [PAGE_BITS-1:0] cur_offset;
  logic [1:0]           cur_kind;
  logic                 cur_super;
  logic                 pf, pv;
  logic [PA_W-1:0]      pa;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)      base_q <= '0;
    else if (cfg_base_we) base_q <= cfg_base;
  end

  xlat_walker #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
    .MEM_DW(MEM_DW), .PTE_BYTES(PTE_BYTES)
  ) walker_i (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_super(req_super), .ptbase(base_q),
    .tlb_hit(tlb_hit), .cur_vpn(cur_vpn), .cur_offset(cur_offset),
    .cur_kind(cur_kind), .cur_super(cur_super),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tlb_we(tlb_we), .use_walk(use_walk),
    .pte_valid(pte_valid), .pte_ppn(pte_ppn), .pte_perm(pte_perm),
    .rsp_valid(walk_rsp)
  );

  xlat_tlb #(
    .ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) tlb_i (
    .clk(clk), .rst_n(rst_n_int), .flush(tlb_flush),
    .lk_vpn(cur_vpn), .lk_hit(tlb_hit), .lk_ppn(tlb_ppn), .lk_perm(tlb_perm),
    .wr_en(tlb_we), .wr_vpn(cur_vpn), .wr_ppn(pte_ppn), .wr_perm(pte_perm)
  );

  // cached entries are always valid; only the walk path can carry an invalid one
  assign chk_ppn  = use_walk ? pte_ppn  : tlb_ppn;
  assign chk_perm = use_walk ? pte_perm : tlb_perm;

  xlat_perm #(
    .PPN_W(PPN_W), .PAGE_BITS(PAGE_BITS)
  ) perm_i (
    .ent_valid(use_walk ? pte_valid : 1'b1), .ent_perm(chk_perm),
    .ent_ppn(chk_ppn), .acc_kind(cur_kind), .acc_super(cur_super),
    .acc_offset(cur_offset), .page_fault(pf), .prot_fault(pv), .paddr(pa)
  );

  assign rsp_valid      = walk_rsp;
  assign rsp_paddr      = walk_rsp ? pa : '0;
  assign rsp_page_fault = walk_rsp && pf;
  assign rsp_prot_fault = walk_rsp && pv;

  assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_paddr == '0));

  assert_single_fault_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));

  assert_no_walk_while_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_ready |-> !mem_req_valid);

endmodule

// File: tb/xlat_mmu_tb_top.sv
module xlat_mmu_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_base_we, tlb_flush;
  logic [31:0] cfg_base;
  logic        req_valid, req_ready, req_super;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        rsp_valid, rsp_page_fault, rsp_prot_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_mmu dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
    .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_page_fault(rsp_page_fault),
    .rsp_prot_fault(rsp_prot_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int total = 0;
  int bad = 0;
  int mem_cnt = 0;
  logic [33:0] sb_q[$];
  string       tag_q[$];
  logic [31:0] addr_q[$];
  logic [31:0] pt_mem [logic [31:0]];

  localparam logic [33:0] EXP_PF   = {2'b10, 32'h0};
  localparam logic [33:0] EXP_PROT = {2'b01, 32'h0};
  localparam logic [1:0]  K_RD = 2'b00, K_WR = 2'b01, K_EX = 2'b10;

  function automatic logic [33:0] exp_ok(input logic [31:0] pa);
    return {2'b00, pa};
  endfunction

  // flags: {supervisor-only, execute, write, valid} in bits 3:0 (R3)
  function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input logic [3:0] fl);
    return {ppn, 8'h5A, fl};
  endfunction

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every response
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid === 1'b1) begin
        if (sb_q.size() == 0) chk("R8 unexpected response", 34'd1, 34'd0);
        else chk({tag_q.pop_front(), " response"},
                 {rsp_page_fault, rsp_prot_fault, rsp_paddr}, sb_q.pop_front());
      end
    end
  end

  // page-table memory model with varying accept delay
  initial begin
    logic [31:0] a;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid === 1'b1) begin
        mem_cnt++;
        a = mem_req_addr;
        if (addr_q.size() == 0) chk("R2 unexpected table read", {2'b0, a}, 34'h0);
        else chk("R2 entry address", {2'b0, a}, {2'b0, addr_q.pop_front()});
        repeat (mem_cnt % 3) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pt_mem.exists(a) ? pt_mem[a] : 32'h0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // driver: starts and ends on a falling edge
  task automatic do_req(input logic [31:0] va, input logic [1:0] kind, input logic sup,
                        input logic [33:0] exp, input logic walk,
                        input logic [31:0] waddr, input string tag);
    int m0;
    m0 = mem_cnt;
    sb_q.push_back(exp);
    tag_q.push_back(tag);
    if (walk) addr_q.push_back(waddr);
    req_vaddr = va;
    req_kind  = kind;
    req_super = sup;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 busy after accept"}, {33'h0, req_ready}, 34'h0);
    chk({tag, " R1 hit latency"}, {33'h0, rsp_valid}, {33'h0, !walk});
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({tag, " R2 table reads"}, 34'(mem_cnt - m0), 34'(walk));
  endtask

  task automatic pulse_flush();
    tlb_flush = 1'b1;
    @(negedge clk);
    tlb_flush = 1'b0;
  endtask

  localparam logic [31:0] BASE0 = 32'h0010_0000;
  localparam logic [31:0] BASE1 = 32'h0020_0000;

  initial begin
    rst_n = 1'b0;
    cfg_base_we = 1'b0; cfg_base = '0; tlb_flush = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_super = 1'b0;

    pt_mem[BASE0 + 32'h04] = mk_pte(20'h00AB1, 4'b0011);
    pt_mem[BASE0 + 32'h08] = mk_pte(20'h00AB2, 4'b1101);
    pt_mem[BASE0 + 32'h0C] = mk_pte(20'h00AB3, 4'b0110);
    pt_mem[BASE0 + 32'h10] = mk_pte(20'h00AB4, 4'b0001);
    for (int v = 10; v <= 15; v++) pt_mem[BASE0 + 32'(v * 4)] = mk_pte(20'(32'h100 + v), 4'b0011);
    pt_mem[BASE1 + 32'h04] = mk_pte(20'h0CCC1, 4'b0011);

    repeat (3) @(negedge clk);
    chk("R9 ready in reset", {33'h0, req_ready}, 34'h1);
    chk("R9 no response in reset", {33'h0, rsp_valid}, 34'h0);
    chk("R9 no read in reset", {33'h0, mem_req_valid}, 34'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 ready after reset", {33'h0, req_ready}, 34'h1);

    cfg_base_we = 1'b1; cfg_base = BASE0;
    @(negedge clk);
    cfg_base_we = 1'b0;

    do_req(32'h0000_1345, K_RD, 1'b0, exp_ok(32'h00AB_1345), 1'b1, BASE0 + 32'h04, "R2 R9 first walk");
    do_req(32'h0000_1010, K_WR, 1'b0, exp_ok(32'h00AB_1010), 1'b0, 32'h0, "R1 write hit");
    do_req(32'h0000_1FFF, 2'b11, 1'b1, exp_ok(32'h00AB_1FFF), 1'b0, 32'h0, "R5 kind 3 read");
    do_req(32'h0000_1000, K_EX, 1'b0, EXP_PROT, 1'b0, 32'h0, "R5 fetch no-exec hit");
    do_req(32'h0000_2008, K_EX, 1'b1, exp_ok(32'h00AB_2008), 1'b1, BASE0 + 32'h08, "R3 supervisor fetch");
    do_req(32'h0000_2008, K_EX, 1'b0, EXP_PROT, 1'b0, 32'h0, "R5 user on supervisor page");
    do_req(32'h0000_300C, K_RD, 1'b1, EXP_PF, 1'b1, BASE0 + 32'h0C, "R4 invalid entry");
    do_req(32'h0000_300C, K_RD, 1'b1, EXP_PF, 1'b1, BASE0 + 32'h0C, "R4 invalid walked again");
    do_req(32'h0000_4444, K_WR, 1'b0, EXP_PROT, 1'b1, BASE0 + 32'h10, "R5 write read-only walk");
    do_req(32'h0000_4444, K_RD, 1'b0, exp_ok(32'h00AB_4444), 1'b0, 32'h0, "R1 read-only page hit");

    for (int v = 10; v <= 14; v++)
      do_req(32'(v) << 12, K_RD, 1'b0, exp_ok(32'(32'h100 + v) << 12), 1'b1,
             BASE0 + 32'(v * 4), "R6 fill");
    do_req(32'h0000_F123, K_RD, 1'b0, exp_ok(32'h0010_F123), 1'b1, BASE0 + 32'h3C, "R6 ninth page");
    do_req(32'h0000_2000, K_RD, 1'b1, exp_ok(32'h00AB_2000), 1'b0, 32'h0, "R6 second fill kept");
    do_req(32'h0000_1004, K_RD, 1'b0, exp_ok(32'h00AB_1004), 1'b1, BASE0 + 32'h04, "R6 oldest evicted");
    do_req(32'h0000_F000, K_RD, 1'b0, exp_ok(32'h0010_F000), 1'b0, 32'h0, "R6 newest kept");

    pulse_flush();
    do_req(32'h0000_F000, K_RD, 1'b0, exp_ok(32'h0010_F000), 1'b1, BASE0 + 32'h3C, "R7 walk after flush");

    cfg_base_we = 1'b1; cfg_base = BASE1;
    @(negedge clk);
    cfg_base_we = 1'b0;
    pulse_flush();
    do_req(32'h0000_1ABC, K_RD, 1'b0, exp_ok(32'h0CCC_1ABC), 1'b1, BASE1 + 32'h04, "R10 new base");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule